// File: doc/BRIEF.md
# Serial EEPROM Byte Access Sequencer

This block runs complete single-byte transactions against a two-wire serial EEPROM. It sits above a byte-level two-wire master and hands it one step at a time. A step is a byte write that may carry a START or a repeated START, a byte read with ACK or NACK, or a STOP. The block moves to the next step only when the master reports that the current one is complete. On the request side it takes a chip/page select, a word address and a write byte, plus one strobe for write and one for read.

A write sends the control byte, the word address and the data byte, then STOP. The block then holds off for the EEPROM's internal programming time, so the caller cannot start the next access too early. A random read first performs a dummy write that loads the word address. It then issues a repeated START with the read control byte and reads one byte, which it does not acknowledge, and finishes with STOP. If a slave fails to acknowledge any byte the block sends, the block issues STOP at once and reports the transaction as failed.

Top module: `eep_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bm_req_o are low.
- R2: A write strobe produces, in order: a byte write with START carrying the write control byte, a byte write of the word address, a byte write of the data byte, then STOP. Step codes on bm_op_o are 0 for byte write, 1 for byte read and 2 for STOP.
- R3: A read strobe produces, in order: a byte write with START carrying the write control byte, a byte write of the word address, a byte write with START (repeated START) carrying the read control byte, a byte read with bm_nack_o high and bm_data_o zero, then STOP.
- R4: The control byte is {4'b1010, dev_sel_i[2:0], rw}, with rw = 0 for the write control byte and rw = 1 for the read control byte.
- R5: bm_req_o is a one-cycle strobe, and it is not raised again until bm_done_i has reported the previous step complete.
- R6: If bm_ack_i is low when a sent byte completes, the next step is STOP, and the transaction then ends with done_o and err_o both high.
- R7: After the STOP of a successful write completes, done_o rises exactly WAIT_CYC+1 cycles after the cycle in which bm_done_i is high, where WAIT_CYC = CLK_HZ/1e6*WCYC_US. After a read, or after a failed transaction, done_o follows in the next cycle.
- R8: busy_o is high from the cycle after a strobe is accepted up to and including the done_o cycle. Strobes that arrive while busy_o is high start nothing.
- R9: done_o is a single-cycle pulse. rdata_o takes the received byte when a read succeeds and keeps it through later writes and failed reads.
- R10: When wr_i and rd_i are high together, a write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request strobe |
| rd_i | input | 1 | Read request strobe |
| dev_sel_i | input | SEL_W | Chip/page select bits of the control byte |
| waddr_i | input | AW | Word address |
| wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction complete (pulse) |
| err_o | output | 1 | Missing acknowledge, valid with done_o |
| rdata_o | output | 8 | Last byte read |
| bm_req_o | output | 1 | Step request to byte master (pulse) |
| bm_op_o | output | 2 | Step code: 0 write, 1 read, 2 STOP |
| bm_start_o | output | 1 | Precede the byte with (repeated) START |
| bm_nack_o | output | 1 | Do not acknowledge the read byte |
| bm_data_o | output | 8 | Byte to send |
| bm_done_i | input | 1 | Byte master step complete (pulse) |
| bm_ack_i | input | 1 | Slave acknowledged, valid with bm_done_i |
| bm_rdata_i | input | 8 | Byte received, valid with bm_done_i |

## Verification
The checker assumes that the byte master raises bm_done_i only for one cycle, only while a step is outstanding, and at least one cycle after the request strobe. It also assumes that bm_ack_i and bm_rdata_i are meaningful only alongside bm_done_i. The bench's master model answers each request two cycles later with a one-cycle completion, so it stays inside these assumptions. The model can withhold ACK at a chosen step of a transaction. It also pokes request strobes in the middle of a transaction to show that they are ignored.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } bm_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVW,
    ST_WADR,
    ST_DATA,
    ST_DEVR,
    ST_RDB,
    ST_STOP,
    ST_WAIT,
    ST_DONE
  } step_e;
endpackage

// File: rtl/eep_req_latch.sv
module eep_req_latch #(
  parameter int SEL_W = 3,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [7:0]       wdata_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic             is_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      waddr_o <= '0;
      wdata_o <= '0;
      is_rd_o <= 1'b0;
    end else if (accept_i) begin
      sel_o   <= sel_i;
      waddr_o <= waddr_i;
      wdata_o <= wdata_i;
      is_rd_o <= rd_i & ~wr_i;  // write wins
    end
  end
endmodule

// File: rtl/eep_wcyc_timer.sv
module eep_wcyc_timer #(
  parameter int WAIT_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(WAIT_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/eep_step_fsm.sv
module eep_step_fsm
  import eep_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int AW    = 8,
  parameter logic [6-SEL_W:0] DEV_ID = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic             is_rd_i,
  output logic             accept_o,
  output logic             tmr_start_o,
  input  logic             tmr_exp_i,
  output logic             bm_req_o,
  output logic [1:0]       bm_op_o,
  output logic             bm_start_o,
  output logic             bm_nack_o,
  output logic [7:0]       bm_data_o,
  input  logic             bm_done_i,
  input  logic             bm_ack_i,
  input  logic [7:0]       bm_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       rdata_o
);
  step_e      step_q, step_d;
  logic       issued_q, issued_d;
  logic       fail_q, fail_d;
  logic [7:0] rdata_q, rdata_d;
  logic [7:0] ctrl_w;
  logic       in_step, fin;

  assign ctrl_w = {DEV_ID, sel_i, 1'b0};
  assign in_step = (step_q inside {ST_DEVW, ST_WADR, ST_DATA, ST_DEVR, ST_RDB, ST_STOP});
  assign fin     = issued_q && bm_done_i;

  // step output decode
  always_comb begin
    bm_op_o    = OP_WR;
    bm_start_o = 1'b0;
    bm_nack_o  = 1'b0;
    bm_data_o  = '0;
    unique case (step_q)
      ST_DEVW: begin bm_start_o = 1'b1; bm_data_o = ctrl_w; end
      ST_WADR: bm_data_o = 8'(waddr_i);
      ST_DATA: bm_data_o = wdata_i;
      ST_DEVR: begin bm_start_o = 1'b1; bm_data_o = ctrl_w | 8'h01; end
      ST_RDB:  begin bm_op_o = OP_RD; bm_nack_o = 1'b1; end
      ST_STOP: bm_op_o = OP_STOP;
      default: ;
    endcase
  end

  always_comb begin
    step_d      = step_q;
    issued_d    = issued_q;
    fail_d      = fail_q;
    rdata_d     = rdata_q;
    accept_o    = 1'b0;
    tmr_start_o = 1'b0;
    if (in_step && !issued_q) issued_d = 1'b1;
    else if (fin)             issued_d = 1'b0;
    unique case (step_q)
      ST_IDLE: if (wr_i || rd_i) begin
        accept_o = 1'b1;
        fail_d   = 1'b0;
        step_d   = ST_DEVW;
      end
      ST_DEVW: if (fin) step_d = bm_ack_i ? ST_WADR : ST_STOP;
      ST_WADR: if (fin) step_d = !bm_ack_i ? ST_STOP : (is_rd_i ? ST_DEVR : ST_DATA);
      ST_DATA: if (fin) step_d = ST_STOP;
      ST_DEVR: if (fin) step_d = bm_ack_i ? ST_RDB : ST_STOP;
      ST_RDB:  if (fin) begin
        rdata_d = bm_rdata_i;
        step_d  = ST_STOP;
      end
      ST_STOP: if (fin) begin
        if (fail_q || is_rd_i) step_d = ST_DONE;
        else begin
          step_d      = ST_WAIT;
          tmr_start_o = 1'b1;
        end
      end
      ST_WAIT: if (tmr_exp_i) step_d = ST_DONE;
      ST_DONE: step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
    // missing ACK on any sent byte
    if (fin && !bm_ack_i && (step_q inside {ST_DEVW, ST_WADR, ST_DATA, ST_DEVR}))
      fail_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_IDLE;
      issued_q <= 1'b0;
      fail_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      step_q   <= step_d;
      issued_q <= issued_d;
      fail_q   <= fail_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bm_req_o = in_step && !issued_q;
  assign busy_o   = (step_q != ST_IDLE);
  assign done_o   = (step_q == ST_DONE);
  assign err_o    = done_o && fail_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int WCYC_US = 5000,
  parameter int SEL_W   = 3,
  parameter int AW      = 8,
  parameter logic [6-SEL_W:0] DEV_ID = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [7:0]       wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       rdata_o,
  output logic             bm_req_o,
  output logic [1:0]       bm_op_o,
  output logic             bm_start_o,
  output logic             bm_nack_o,
  output logic [7:0]       bm_data_o,
  input  logic             bm_done_i,
  input  logic             bm_ack_i,
  input  logic [7:0]       bm_rdata_i
);
  localparam int RAW_CYC  = (CLK_HZ / 1_000_000) * WCYC_US;
  localparam int WAIT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  logic             accept, is_rd, tmr_start, tmr_exp;
  logic [SEL_W-1:0] sel_l;
  logic [AW-1:0]    waddr_l;
  logic [7:0]       wdata_l;

  eep_req_latch #(.SEL_W(SEL_W), .AW(AW)) u_latch (
    .clk_i, .rst_ni, .accept_i(accept), .wr_i, .rd_i,
    .sel_i(dev_sel_i), .waddr_i, .wdata_i,
    .sel_o(sel_l), .waddr_o(waddr_l), .wdata_o(wdata_l), .is_rd_o(is_rd)
  );

  eep_wcyc_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(tmr_start), .expired_o(tmr_exp)
  );

  eep_step_fsm #(.SEL_W(SEL_W), .AW(AW), .DEV_ID(DEV_ID)) u_fsm (
    .clk_i, .rst_ni, .wr_i, .rd_i,
    .sel_i(sel_l), .waddr_i(waddr_l), .wdata_i(wdata_l), .is_rd_i(is_rd),
    .accept_o(accept), .tmr_start_o(tmr_start), .tmr_exp_i(tmr_exp),
    .bm_req_o, .bm_op_o, .bm_start_o, .bm_nack_o, .bm_data_o,
    .bm_done_i, .bm_ack_i, .bm_rdata_i,
    .busy_o, .done_o, .err_o, .rdata_o
  );
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       bm_req_o,
  input logic       bm_start_o,
  input logic [7:0] bm_data_o,
  input logic       bm_done_i
);
  logic out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= 1'b0;
    else if (bm_req_o)  out_q <= 1'b1;
    else if (bm_done_i) out_q <= 1'b0;
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_req_o |-> !out_q);
  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_req_o |=> !bm_req_o);
  // R4
  ctrl_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_req_o && bm_start_o) |-> (bm_data_o[7:4] == 4'b1010));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (wr_i || rd_i)) |=> busy_o);
  // R6
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R8
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind eep_seq eep_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .bm_req_o(bm_req_o), .bm_start_o(bm_start_o), .bm_data_o(bm_data_o),
  .bm_done_i(bm_done_i)
);

// File: tb/sim_eep_seq.sv
`timescale 1ns/1ps
module sim_eep_seq;
  localparam int W = 40;  // CLK_HZ 1 MHz * 40 us

  typedef struct packed {
    logic [1:0] op;
    logic       start;
    logic [7:0] data;
    logic       nack;
  } step_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] waddr = '0, wdata = '0;
  logic       busy, done, err;
  logic [7:0] rdata;
  logic       bm_req, bm_start, bm_nack;
  logic [1:0] bm_op;
  logic [7:0] bm_data;
  logic       bm_done = 1'b0, bm_ack = 1'b0;
  logic [7:0] bm_rdata = '0;

  int   total = 0, bad = 0, cyc = 0, stop_cyc = 0;
  int   fail_step = -1, op_idx = 0;
  logic [7:0] rd_val = '0;
  step_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  eep_seq #(.CLK_HZ(1_000_000), .WCYC_US(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .dev_sel_i(sel), .waddr_i(waddr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .bm_req_o(bm_req), .bm_op_o(bm_op), .bm_start_o(bm_start),
    .bm_nack_o(bm_nack), .bm_data_o(bm_data),
    .bm_done_i(bm_done), .bm_ack_i(bm_ack), .bm_rdata_i(bm_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // master model + scoreboard monitor
  initial begin
    step_t e, a;
    forever begin
      @(negedge clk);
      bm_done = 1'b0;
      if (bm_req) begin
        a = '{op: bm_op, start: bm_start, data: bm_data, nack: bm_nack};
        if (exp_q.size() == 0) check("R2/R3/R8 unexpected step", int'(a), -1);
        else begin
          e = exp_q.pop_front();
          check("R2/R3/R4 step", int'(a), int'(e));
        end
        repeat (2) @(negedge clk);
        bm_done  = 1'b1;
        bm_ack   = (op_idx != fail_step);
        bm_rdata = rd_val;
        if (a.op == 2'd2) stop_cyc = cyc;
        op_idx++;
      end
    end
  end

  function automatic step_t mk(input logic [1:0] op, input logic st,
                               input logic [7:0] d, input logic nk);
    return '{op: op, start: st, data: d, nack: nk};
  endfunction

  task automatic run(input string tag, input bit is_wr, input bit both,
                     input logic [2:0] s, input logic [7:0] ad, input logic [7:0] d,
                     input logic [7:0] rv, input int fstep, input bit poke,
                     input logic [7:0] exp_rdata);
    step_t full[4];
    int    n;
    logic [7:0] cw;
    cw = {4'b1010, s, 1'b0};  // R4
    full[0] = mk(2'd0, 1'b1, cw, 1'b0);
    full[1] = mk(2'd0, 1'b0, ad, 1'b0);
    if (is_wr) full[2] = mk(2'd0, 1'b0, d, 1'b0);
    else begin
      full[2] = mk(2'd0, 1'b1, cw | 8'h01, 1'b0);
      full[3] = mk(2'd1, 1'b0, 8'h00, 1'b1);
    end
    n = is_wr ? 3 : 4;
    if (fstep >= 0) n = fstep + 1;
    for (int i = 0; i < n; i++) exp_q.push_back(full[i]);
    exp_q.push_back(mk(2'd2, 1'b0, 8'h00, 1'b0));
    op_idx = 0; fail_step = fstep; rd_val = rv;
    sel = s; waddr = ad; wdata = d;
    wr = is_wr | both; rd = ~is_wr | both;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check({tag, " R8 busy after accept"}, int'(busy), 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      rd = 1'b1; waddr = 8'h99; sel = 3'd2;
      @(negedge clk);
      rd = 1'b0;
    end
    while (!done) @(negedge clk);
    check({tag, " R6 err"}, int'(err), int'(fstep >= 0));
    check({tag, " R7 done latency"}, cyc - stop_cyc,
          (is_wr && fstep < 0) ? W + 1 : 1);
    check({tag, " R9 rdata"}, int'(rdata), int'(exp_rdata));
    @(negedge clk);
    check({tag, " R9 done pulse"}, int'(done), 0);
    check({tag, " R8 idle"}, int'(busy), 0);
    repeat (6) @(negedge clk);
    check({tag, " R2/R3 queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 req", int'(bm_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R4 R7
    run("wr1", 1, 0, 3'd0, 8'h12, 8'h5A, 8'h00, -1, 0, 8'h00);
    // R8 ignore while busy
    run("wr2", 1, 0, 3'd5, 8'hFF, 8'h00, 8'h00, -1, 1, 8'h00);
    // R3 R9
    run("rd1", 0, 0, 3'd0, 8'h34, 8'h00, 8'hC3, -1, 0, 8'hC3);
    run("rd2", 0, 0, 3'd7, 8'h00, 8'h00, 8'h7E, -1, 1, 8'h7E);
    // R6 device NACK on write
    run("wr_nack_dev", 1, 0, 3'd1, 8'h40, 8'hAA, 8'h00, 0, 0, 8'h7E);
    // R6 read control NACK, rdata kept
    run("rd_nack_ctl", 0, 0, 3'd3, 8'h41, 8'h00, 8'h11, 2, 0, 8'h7E);
    // R6 data NACK
    run("wr_nack_dat", 1, 0, 3'd6, 8'h42, 8'h3C, 8'h00, 2, 0, 8'h7E);
    // R6 word address NACK on read
    run("rd_nack_adr", 0, 0, 3'd4, 8'h43, 8'h00, 8'h22, 1, 0, 8'h7E);
    // R10 both strobes -> write
    run("both", 1, 1, 3'd2, 8'h80, 8'hE7, 8'h55, -1, 0, 8'h7E);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule